// File: doc/BRIEF.md
# Firmware-Memory Bus Target Decoder

This block is the bus-facing front end of a boot flash device that sits on a 4-bit LPC bus. On every clock it samples the frame strobe and the four data lines. From them it parses firmware-memory read and write cycles, which run through these phases:

- the start nibble;
- the device-select nibble;
- seven address nibbles;
- the size nibble;
- the write data, when the cycle is a write;
- the turnarounds;
- the handshake (SYNC) nibble;
- the read data, when the cycle is a read.

The device-select nibble is compared against four static strap inputs, so up to sixteen such devices can share one bus. The device answers only when the select nibble matches its own straps.

Of the 28 address bits, only the low nineteen and bit 22 are kept. Bit 22 chooses between the flash core (1) and the register space (0). Each accepted cycle becomes one single-byte request on a simple backend port: a one-clock request pulse carrying the address, the space bit, a write flag and the write data. For a read, the backend returns the byte one clock after the pulse.

The decoder only drives the data lines during the handshake, read-data and closing turnaround clocks, and signals this with an output-enable. Whenever the frame strobe goes low, the current cycle ends at once and the decoder stops driving. The decoder never clears anything the backend holds, so a multi-step command sequence on the backend survives an aborted cycle. When the backend reports busy, write cycles are still acknowledged on the bus but no write request is issued.

Top module: `fwm_target`

## Requirements
- R1: After reset, ladOe is 0 and reqValid is 0.
- R2: The start nibble is the value on ladIn in the last clock with frameN low. A value of 1101b starts a read and 1110b starts a write. Any other value, including the 1111b abort nibble, is ignored: the lines are not driven and no request is issued.
- R3: The clock after the start nibble carries the device-select nibble. If it differs from strapId, the cycle is ignored: the lines are never driven and no request is issued.
- R4: The seven address nibbles arrive most significant first and form a 28-bit address. The request presents address bits 18:0 on reqAddr and bit 22 on reqSpace (1 = flash core, 0 = register space). All other address bits have no effect.
- R5: A size nibble other than 0000b makes the decoder ignore the cycle, with no request and no drive.
- R6: Read timing. reqValid (with reqWrite 0) pulses in the clock after the size nibble. The decoder samples rspRdata one clock after that pulse. After two host turnaround clocks, the decoder drives SYNC 0000b, then the data's low nibble, then its high nibble.
- R7: Write timing. The data byte follows the size nibble, low nibble first. After two host turnaround clocks, the decoder drives SYNC 0000b. In the next clock, reqValid pulses with reqWrite 1 and the assembled byte on reqWdata.
- R8: After the last nibble it drives, the decoder drives 1111b for one clock and then releases the lines. Outside the SYNC, read-data and that turnaround clock, ladOe is 0.
- R9: If busy is 1 during the SYNC clock of a write, the write is still acknowledged with SYNC and turnaround, but no request is issued.
- R10: Whenever frameN is low, ladOe is 0 and the current cycle ends: no later request belongs to it. A following valid cycle, including a re-sent copy of the aborted one, completes normally.
- R11: reqValid is high for exactly one clock per accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| ladIn | input | 4 | Sampled value of the shared data lines |
| strapId | input | 4 | Static device-select straps |
| ladOut | output | 4 | Value driven onto the data lines |
| ladOe | output | 1 | Output enable for the data lines |
| reqValid | output | 1 | One-clock backend request strobe |
| reqWrite | output | 1 | Request is a write (1) or a read (0) |
| reqSpace | output | 1 | 1 = flash core, 0 = register space |
| reqAddr | output | 19 | Byte address within the selected space |
| reqWdata | output | 8 | Write data byte |
| rspRdata | input | 8 | Read data from the backend, valid one clock after a read request |
| busy | input | 1 | Backend erase or program in progress |

## Verification
The assertions take the following for granted about the environment:
- strapId stays constant for the length of a bus cycle;
- busy is steady across a write's SYNC clock;
- the backend presents rspRdata in the clock after a read pulse.

The bench keeps within these assumptions. It changes the straps only between cycles, sets busy before each cycle starts, and models the backend as a registered lookup that answers in the clock after each read pulse.

Random cycles mix valid and invalid start, select and size nibbles with random addresses and busy values. Directed cases cover an abort during SYNC, an abort during write data followed by a re-send, a restart in the middle of the address phase, and an abort nibble followed by a select value that matches the straps.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
  localparam int NIB_W      = 4;
  localparam int ADDR_NIBS  = 7;
  localparam int ADDR_W     = NIB_W * ADDR_NIBS;
  localparam int SPACE_BIT  = 22;
  localparam int LOW_W      = 19;
  localparam int DATA_W     = 8;
  localparam int DATA_NIBS  = DATA_W / NIB_W;
  localparam int HTAR_CLKS  = 2;
  localparam int NIB_IDX_W  = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1;
  localparam int CNT_W      = $clog2(ADDR_NIBS);
  localparam int SPACE_NIB  = (ADDR_W - 1 - SPACE_BIT) / NIB_W;
  localparam int SPACE_POS  = SPACE_BIT % NIB_W;

  localparam logic [NIB_W-1:0] START_RD   = 4'b1101;
  localparam logic [NIB_W-1:0] START_WR   = 4'b1110;
  localparam logic [NIB_W-1:0] SIZE_BYTE  = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
  localparam logic [NIB_W-1:0] TAR_NIB    = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_FRAME, S_ADDR, S_MSIZE, S_WDATA, S_HTAR, S_SYNC, S_RDATA, S_TTAR
  } stateT;

  typedef enum logic [1:0] {DRV_NONE, DRV_SYNC, DRV_DATA, DRV_TAR} drvT;

  typedef struct packed {
    logic                 shiftAddr;
    logic                 capSpace;
    logic                 capWnib;
    logic                 capRdata;
    logic                 issueRd;
    logic                 issueWr;
    drvT                  drv;
    logic [NIB_IDX_W-1:0] nibIdx;
  } strobeT;
endpackage

// File: rtl/fwm_ctrl.sv
module fwm_ctrl
  import fwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic [NIB_W-1:0] ladIn,
  input  logic [NIB_W-1:0] strapId,
  input  logic             busy,
  output strobeT           st
);
  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic [NIB_W-1:0] startNib;
  logic             startOk;

  assign startOk = (startNib == START_RD) || (startNib == START_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      isWrite  <= 1'b0;
      startNib <= '0;
    end else if (!frameN) begin
      state    <= S_FRAME;
      startNib <= ladIn;
      cnt      <= '0;
    end else begin
      case (state)
        S_FRAME: begin
          cnt <= '0;
          if (startOk && ladIn == strapId) begin
            state   <= S_ADDR;
            isWrite <= (startNib == START_WR);
          end else begin
            state <= S_IDLE;
          end
        end
        S_ADDR: begin
          if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
            state <= S_MSIZE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_MSIZE: begin
          cnt <= '0;
          if (ladIn != SIZE_BYTE) state <= S_IDLE;
          else state <= isWrite ? S_WDATA : S_HTAR;
        end
        S_WDATA: begin
          if (cnt == CNT_W'(DATA_NIBS - 1)) begin
            state <= S_HTAR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_HTAR: begin
          if (cnt == CNT_W'(HTAR_CLKS - 1)) begin
            state <= S_SYNC;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_SYNC: begin
          cnt   <= '0;
          state <= isWrite ? S_TTAR : S_RDATA;
        end
        S_RDATA: begin
          if (cnt == CNT_W'(DATA_NIBS - 1)) begin
            state <= S_TTAR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_TTAR:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st     = '0;
    st.drv = DRV_NONE;
    if (frameN) begin
      case (state)
        S_ADDR: begin
          st.shiftAddr = 1'b1;
          st.capSpace  = (cnt == CNT_W'(SPACE_NIB));
        end
        S_MSIZE: st.issueRd = !isWrite && (ladIn == SIZE_BYTE);
        S_WDATA: begin
          st.capWnib = 1'b1;
          st.nibIdx  = cnt[NIB_IDX_W-1:0];
        end
        S_HTAR:  st.capRdata = !isWrite && (cnt == CNT_W'(HTAR_CLKS - 1));
        S_SYNC: begin
          st.drv     = DRV_SYNC;
          st.issueWr = isWrite && !busy;
        end
        S_RDATA: begin
          st.drv    = DRV_DATA;
          st.nibIdx = cnt[NIB_IDX_W-1:0];
        end
        S_TTAR:  st.drv = DRV_TAR;
        default: st.drv = DRV_NONE;
      endcase
    end
  end

  // R10: a low frame strobe always pulls the sequencer back to start capture
  p_abort_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> state == S_FRAME);

  // R3: a select mismatch leaves the cycle unanswered
  p_idsel_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FRAME && frameN && ladIn != strapId) |=> state == S_IDLE);

  // R11: at most one backend action per clock
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.issueRd, st.issueWr, st.capRdata}));
endmodule

// File: rtl/fwm_dpath.sv
module fwm_dpath
  import fwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  ladIn,
  input  logic [DATA_W-1:0] rspRdata,
  input  strobeT            st,
  output logic [NIB_W-1:0]  ladOut,
  output logic              ladOe,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqSpace,
  output logic [LOW_W-1:0]  reqAddr,
  output logic [DATA_W-1:0] reqWdata
);
  logic [LOW_W-1:0]  lowAddr;
  logic              spaceBit;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [NIB_W-1:0]  rdNib [DATA_NIBS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowAddr  <= '0;
      spaceBit <= 1'b0;
      wdata    <= '0;
      rdata    <= '0;
      reqValid <= 1'b0;
      reqWrite <= 1'b0;
    end else begin
      if (st.shiftAddr) lowAddr <= {lowAddr[LOW_W-NIB_W-1:0], ladIn};
      if (st.capSpace)  spaceBit <= ladIn[SPACE_POS];
      if (st.capWnib) begin
        for (int i = 0; i < DATA_NIBS; i++)
          if (st.nibIdx == NIB_IDX_W'(i)) wdata[i*NIB_W +: NIB_W] <= ladIn;
      end
      if (st.capRdata) rdata <= rspRdata;
      reqValid <= st.issueRd | st.issueWr;
      reqWrite <= st.issueWr;
    end
  end

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_rdnib
    assign rdNib[g] = rdata[g*NIB_W +: NIB_W];
  end

  always_comb begin
    ladOe  = 1'b0;
    ladOut = '0;
    case (st.drv)
      DRV_SYNC: begin ladOe = 1'b1; ladOut = SYNC_READY; end
      DRV_DATA: begin ladOe = 1'b1; ladOut = rdNib[st.nibIdx]; end
      DRV_TAR:  begin ladOe = 1'b1; ladOut = TAR_NIB; end
      default:  begin ladOe = 1'b0; ladOut = '0; end
    endcase
  end

  assign reqAddr  = lowAddr;
  assign reqSpace = spaceBit;
  assign reqWdata = wdata;

  // R11: each request is a single-clock pulse
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // R8: the closing turnaround clock is followed by released lines
  p_tar_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.drv == DRV_TAR) |=> !ladOe);
endmodule

// File: rtl/fwm_target.sv
module fwm_target
  import fwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        ladIn,
  input  logic [3:0]        strapId,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqSpace,
  output logic [18:0]       reqAddr,
  output logic [7:0]        reqWdata,
  input  logic [7:0]        rspRdata,
  input  logic              busy
);
  strobeT st;

  fwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn),
    .strapId(strapId), .busy(busy), .st(st)
  );

  fwm_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ladIn(ladIn), .rspRdata(rspRdata), .st(st),
    .ladOut(ladOut), .ladOe(ladOe), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqAddr(reqAddr), .reqWdata(reqWdata)
  );

  // R9: no write request follows a busy SYNC clock
  p_busy_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> !$past(busy));

  // R6: the clock after a read request is still host turnaround
  p_read_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> !ladOe);
endmodule

// File: tb/fwm_target_tb.sv
`timescale 1ns/1ps
module fwm_target_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic [3:0] ladIn = 4'hF;
  logic [3:0] strapId = 4'h5;
  logic [3:0] ladOut;
  logic ladOe, reqValid, reqWrite, reqSpace;
  logic [18:0] reqAddr;
  logic [7:0] reqWdata;
  logic [7:0] rspRdata = 8'h00;
  logic busy = 1'b0;

  int checks = 0;
  int errors = 0;
  int reqCount = 0;
  int wrCount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fwm_target u_dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn), .strapId(strapId),
    .ladOut(ladOut), .ladOe(ladOe), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .busy(busy)
  );

  function automatic logic [7:0] memFn(input logic sp, input logic [18:0] a);
    return a[7:0] ^ a[18:11] ^ (sp ? 8'hA5 : 8'h3C);
  endfunction

  // backend model: answers a read in the clock after its pulse
  always @(posedge clk) begin
    if (rstN && reqValid) begin
      reqCount++;
      if (reqWrite) wrCount++;
      else rspRdata <= memFn(reqSpace, reqAddr);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, hold one full clock
  task automatic clk1(input logic f, input logic [3:0] n);
    frameN = f;
    ladIn  = n;
    @(negedge clk);
  endtask

  task automatic doCycle(input logic [3:0] start, input logic [3:0] idsel,
                         input logic [27:0] addr, input logic [3:0] msize,
                         input logic [7:0] wd, input bit bsy);
    bit isWr, resp;
    string tag;
    int r0, w0;
    logic [7:0] exp;
    isWr = (start == 4'hE);
    resp = (start == 4'hD || isWr) && idsel == strapId && msize == 4'h0;
    if (!(start == 4'hD || isWr)) tag = "R2";
    else if (idsel != strapId)    tag = "R3";
    else if (msize != 4'h0)       tag = "R5";
    else if (isWr)                tag = "R7";
    else                          tag = "R6";
    busy = bsy;
    r0 = reqCount;
    w0 = wrCount;
    clk1(1'b0, start);
    clk1(1'b1, idsel);
    for (int i = 0; i < 7; i++) clk1(1'b1, addr[27-4*i -: 4]);
    clk1(1'b1, msize);
    if (isWr) begin
      clk1(1'b1, wd[3:0]);
      clk1(1'b1, wd[7:4]);
      chk(tag, "oe in data", int'(ladOe), 0);
      clk1(1'b1, 4'hF);
      clk1(1'b1, 4'hF);
      chk(tag, "sync oe", int'(ladOe), int'(resp));
      if (resp) chk("R7", "sync value", int'(ladOut), 0);
      clk1(1'b1, 4'hF);
      chk("R8", "tar oe", int'(ladOe), int'(resp));
      if (resp) chk("R8", "tar value", int'(ladOut), 15);
      chk(resp ? "R9" : tag, "write pulse", int'(reqValid && reqWrite), int'(resp && !bsy));
      if (resp && !bsy) begin
        chk("R7", "wdata", int'(reqWdata), int'(wd));
        chk("R4", "waddr", int'(reqAddr), int'(addr[18:0]));
        chk("R4", "wspace", int'(reqSpace), int'(addr[22]));
      end
      clk1(1'b1, 4'hF);
      chk("R8", "released", int'(ladOe), 0);
      chk("R11", "write count", wrCount - w0, int'(resp && !bsy));
    end else begin
      chk(tag, "read pulse", int'(reqValid && !reqWrite), int'(resp));
      if (resp) begin
        chk("R4", "raddr", int'(reqAddr), int'(addr[18:0]));
        chk("R4", "rspace", int'(reqSpace), int'(addr[22]));
      end
      clk1(1'b1, 4'hF);
      chk("R6", "oe in tar", int'(ladOe), 0);
      clk1(1'b1, 4'hF);
      chk(tag, "sync oe", int'(ladOe), int'(resp));
      if (resp) chk("R6", "sync value", int'(ladOut), 0);
      exp = memFn(addr[22], addr[18:0]);
      clk1(1'b1, 4'hF);
      chk(tag, "data lo oe", int'(ladOe), int'(resp));
      if (resp) chk("R6", "data lo", int'(ladOut), int'(exp[3:0]));
      clk1(1'b1, 4'hF);
      if (resp) chk("R6", "data hi", int'(ladOut), int'(exp[7:4]));
      clk1(1'b1, 4'hF);
      chk("R8", "tar oe", int'(ladOe), int'(resp));
      if (resp) chk("R8", "tar value", int'(ladOut), 15);
      clk1(1'b1, 4'hF);
      chk("R8", "released", int'(ladOe), 0);
      chk("R11", "read count", reqCount - r0, int'(resp));
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, w0;
    logic [3:0] st, id, ms;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "oe after reset", int'(ladOe), 0);
    chk("R1", "req after reset", int'(reqValid), 0);

    // directed: basic read and write, both spaces, don't-care bits set
    doCycle(4'hD, 4'h5, 28'hF_C5A_B3C, 4'h0, 8'h00, 1'b0);
    doCycle(4'hD, 4'h5, 28'h0_B81_234, 4'h0, 8'h00, 1'b0);
    doCycle(4'hE, 4'h5, 28'hA_4F7_001, 4'h0, 8'h96, 1'b0);
    doCycle(4'hE, 4'h5, 28'h1_400_0FF, 4'h0, 8'h3C, 1'b1);
    doCycle(4'hE, 4'h3, 28'h0_400_0FF, 4'h0, 8'h3C, 1'b0);
    doCycle(4'hD, 4'h5, 28'h0_400_0FF, 4'h2, 8'h00, 1'b0);
    doCycle(4'h0, 4'h5, 28'h0_400_0FF, 4'h0, 8'h00, 1'b0);

    // R10: abort during read SYNC
    r0 = reqCount;
    clk1(1'b0, 4'hD); clk1(1'b1, 4'h5);
    for (int i = 0; i < 7; i++) clk1(1'b1, 4'h4);
    clk1(1'b1, 4'h0); clk1(1'b1, 4'hF); clk1(1'b1, 4'hF);
    chk("R10", "sync before abort", int'(ladOe), 1);
    clk1(1'b0, 4'hF);
    chk("R10", "oe during abort", int'(ladOe), 0);
    clk1(1'b0, 4'hF); clk1(1'b0, 4'hF);
    clk1(1'b1, 4'h5);
    for (int i = 0; i < 4; i++) begin
      clk1(1'b1, 4'h0);
      chk("R10", "quiet after abort", int'(ladOe), 0);
    end
    chk("R10", "requests from aborted read", reqCount - r0, 1);
    doCycle(4'hD, 4'h5, 28'h0_412_345, 4'h0, 8'h00, 1'b0);

    // R10: abort during write data, then re-send
    w0 = wrCount;
    busy = 1'b0;
    clk1(1'b0, 4'hE); clk1(1'b1, 4'h5);
    for (int i = 0; i < 7; i++) clk1(1'b1, 4'h1);
    clk1(1'b1, 4'h0); clk1(1'b1, 4'hA);
    clk1(1'b0, 4'hF); clk1(1'b0, 4'hF);
    for (int i = 0; i < 6; i++) begin
      clk1(1'b1, 4'hF);
      chk("R10", "no drive after write abort", int'(ladOe), 0);
    end
    chk("R10", "no write from aborted cycle", wrCount - w0, 0);
    doCycle(4'hE, 4'h5, 28'h1_111_111, 4'h0, 8'h5A, 1'b0);

    // R10: restart in the middle of an address
    w0 = wrCount;
    clk1(1'b0, 4'hE); clk1(1'b1, 4'h5);
    clk1(1'b1, 4'h7); clk1(1'b1, 4'h7); clk1(1'b1, 4'h7);
    doCycle(4'hD, 4'h5, 28'h0_4C0_DE0, 4'h0, 8'h00, 1'b0);
    chk("R10", "restart left no write", wrCount - w0, 0);

    // R2/R10: abort nibble followed by a matching select value
    r0 = reqCount;
    clk1(1'b0, 4'hF); clk1(1'b1, 4'h5);
    for (int i = 0; i < 14; i++) begin
      clk1(1'b1, 4'h0);
      chk("R2", "abort nibble not a start", int'(ladOe), 0);
    end
    chk("R2", "abort nibble no request", reqCount - r0, 0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      if (n % 60 == 59) strapId = 4'($urandom);
      case ($urandom % 8)
        0, 1, 2: st = 4'hD;
        3, 4, 5: st = 4'hE;
        6:       st = 4'h0;
        default: st = 4'hC;
      endcase
      id = ($urandom % 4 != 0) ? strapId : 4'($urandom);
      ms = ($urandom % 7 != 0) ? 4'h0 : 4'($urandom);
      doCycle(st, id, 28'($urandom), ms, 8'($urandom), ($urandom % 4) == 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule